// File: doc/BRIEF.md
# DMA Transfer-Mode Address Sequencer

This block is the stepping engine of one general-purpose DMA channel. When a start request arrives, it captures a control byte, a 24-bit source bus address, a 16-bit byte count and an 8-bit register-bus base offset. It then moves one byte per clock cycle until the count is used up.

For every byte it presents three things. The first is the current source address. The second is the register-bus address, which is the base plus an offset taken from a small repeating pattern selected by a 3-bit mode. The third is a pair of strobes: a read on one side and a write on the other. The direction bit decides which side is read and which is written.

The source address can step up, step down or stay fixed. It steps for every byte, whatever the mode. Only its low 16 bits move; the bank byte never changes. When the last byte has been presented, a one-cycle done pulse follows.

Top module: `dma_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr`, `reg_rd` and `reg_wr` are all 0.
- R2: A `start` seen on a clock edge while idle captures the inputs. Byte 0 is presented from that same edge, with `src_addr` equal to the captured address and `reg_addr` equal to the captured base. A `start` seen while `busy` is 1 has no effect on the running transfer.
- R3: Control bit 7 selects the direction. When it is 0, each byte asserts `mem_rd` and `reg_wr`. When it is 1, each byte asserts `reg_rd` and `mem_wr`. While idle, no strobe is asserted.
- R4: Control bits 2:0 select the offset pattern added to the base (8-bit wrap): 000 → (0); 001 → (0,1); 010 → (0,0); 011 → (0,0,1,1); 100 → (0,1,2,3); 101 → (0,1,0,1); 110 → (0,0); 111 → (0,0,1,1).
- R5: The pattern restarts at its first entry at each transfer start. The byte count may end a transfer partway through a pattern.
- R6: When control bit 3 is 0, the low 16 bits of the source address step after every byte, wrapping modulo 65536. They step +1 when control bit 4 is 0 and −1 when it is 1. Bits 23:16 never change during a transfer.
- R7: When control bit 3 is 1, the source address holds its start value for every byte, whatever bit 4 is.
- R8: A count of N (1..65535) gives exactly N busy cycles. A count of 0 gives 65536 busy cycles.
- R9: `done` is 1 for exactly one cycle, in the cycle right after the last byte, with `busy` already 0.
- R10: Control bits 6 and 5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, taken only while idle |
| ctrl | input | 8 | Control byte: direction, unused bits, decrement, fixed, mode |
| src_start | input | 24 | Source bus start address |
| byte_count | input | 16 | Number of bytes; 0 means 65536 |
| reg_base | input | 8 | Register-bus base offset |
| busy | output | 1 | A byte is being presented this cycle |
| done | output | 1 | One-cycle pulse after the last byte |
| src_addr | output | 24 | Source address of the current byte |
| reg_addr | output | 8 | Register-bus address of the current byte |
| mem_rd | output | 1 | Source-side read strobe |
| mem_wr | output | 1 | Source-side write strobe |
| reg_rd | output | 1 | Register-side read strobe |
| reg_wr | output | 1 | Register-side write strobe |

## Verification
A pattern index that is out of step shows on `reg_addr` at the very next byte. A missed restart shows on byte 0 of the following transfer. A wrong step direction or a leak into the bank byte shows on `src_addr` one cycle after the first byte. A length counter that is off by one shows as a `done` pulse that comes one cycle early or late. The bench therefore compares every byte of every transfer against addresses it computes itself, and checks the exact cycle of `done`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef struct packed {
    logic       to_mem;    // 1: register side read, memory side written
    logic       indir;     // not used by this engine
    logic       spare;     // not used
    logic       step_down;
    logic       hold_src;
    logic [2:0] mode;
  } dma_ctrl_t;

  // index mask = pattern length - 1
  function automatic logic [1:0] pat_mask(input logic [2:0] m);
    case (m)
      3'b000:                 return 2'b00;
      3'b001, 3'b010, 3'b110: return 2'b01;
      default:                return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] pat_offset(input logic [2:0] m, input logic [1:0] i);
    case (m)
      3'b001, 3'b101: return {1'b0, i[0]};
      3'b011, 3'b111: return {1'b0, i[1]};
      3'b100:         return i;
      default:        return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/dma_pattern_gen.sv
module dma_pattern_gen #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [2:0]       mode_in,
  input  logic [REG_W-1:0] base_in,
  output logic [REG_W-1:0] reg_addr
);
  import dma_seq_pkg::*;

  logic [2:0]       mode_q;
  logic [REG_W-1:0] base_q;
  logic [1:0]       idx_q;
  logic [1:0]       idx_nx;

  assign idx_nx = (idx_q + 2'd1) & pat_mask(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      base_q   <= '0;
      idx_q    <= '0;
      reg_addr <= '0;
    end else if (load) begin
      mode_q   <= mode_in;
      base_q   <= base_in;
      idx_q    <= '0;
      reg_addr <= base_in;
    end else if (advance) begin
      idx_q    <= idx_nx;
      reg_addr <= base_q + {{(REG_W-2){1'b0}}, pat_offset(mode_q, idx_nx)};
    end
  end

  // offset from base never exceeds 3 (R4)
  assert_offset_range_R4: assert property (@(posedge clk) disable iff (rst)
    $past(advance) |-> ((reg_addr - base_q) <= REG_W'(3)));

  // first byte of a transfer sits on the base (R5)
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (reg_addr == $past(base_in)));

endmodule

// File: rtl/dma_src_stepper.sv
module dma_src_stepper #(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              dec_in,
  input  logic              fix_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr
);
  localparam int BANK_W = ADDR_W - STEP_W;

  logic dec_q, fix_q;
  logic [STEP_W-1:0] low_nx;

  always_comb begin
    if (fix_q)      low_nx = addr[STEP_W-1:0];
    else if (dec_q) low_nx = addr[STEP_W-1:0] - STEP_W'(1);
    else            low_nx = addr[STEP_W-1:0] + STEP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= 1'b0;
      fix_q <= 1'b0;
      addr  <= '0;
    end else if (load) begin
      dec_q <= dec_in;
      fix_q <= fix_in;
      addr  <= addr_in;
    end else if (advance) begin
      addr[STEP_W-1:0] <= low_nx;
    end
  end

  // bank byte untouched by stepping (R6)
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $past(advance) && !$past(load) |-> addr[ADDR_W-1:STEP_W] == $past(addr[ADDR_W-1:STEP_W]));

  // fixed source never moves (R7)
  assert_fixed_src_R7: assert property (@(posedge clk) disable iff (rst)
    advance && fix_q && !load |=> $stable(addr));

  // unit step in the chosen direction (R6)
  assert_step_size_R6: assert property (@(posedge clk) disable iff (rst)
    advance && !fix_q && !load |=>
      (addr[STEP_W-1:0] - $past(addr[STEP_W-1:0])) == ($past(dec_q) ? {STEP_W{1'b1}} : STEP_W'(1)));

  if (BANK_W < 1) begin : g_bad
    initial $error("ADDR_W must exceed STEP_W");
  end
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [CNT_W-1:0] count_in,
  output logic             last
);
  logic [CNT_W:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)          rem_q <= '0;
    else if (load)    rem_q <= (count_in == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_in};
    else if (advance) rem_q <= rem_q - 1'b1;
  end

  assign last = (rem_q == (CNT_W+1)'(1));

  // never steps past the final byte (R8)
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    advance |-> rem_q > (CNT_W+1)'(1));
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top #(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 16,
  parameter int REG_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        ctrl,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [REG_W-1:0]  reg_base,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [REG_W-1:0]  reg_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              reg_rd,
  output logic              reg_wr
);
  import dma_seq_pkg::*;

  dma_ctrl_t cfg;
  logic accept, step, finish, last;

  assign cfg    = dma_ctrl_t'(ctrl);
  assign accept = start & ~busy;
  assign step   = busy & ~last;
  assign finish = busy & last;

  dma_pattern_gen #(.REG_W(REG_W)) u_pat (
    .clk(clk), .rst(rst), .load(accept), .advance(step),
    .mode_in(cfg.mode), .base_in(reg_base), .reg_addr(reg_addr));

  dma_src_stepper #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_src (
    .clk(clk), .rst(rst), .load(accept), .advance(step),
    .dec_in(cfg.step_down), .fix_in(cfg.hold_src),
    .addr_in(src_start), .addr(src_addr));

  dma_len_counter #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst(rst), .load(accept), .advance(step),
    .count_in(byte_count), .last(last));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        mem_rd <= ~cfg.to_mem;
        reg_wr <= ~cfg.to_mem;
        reg_rd <= cfg.to_mem;
        mem_wr <= cfg.to_mem;
      end else if (finish) begin
        busy   <= 1'b0;
        mem_rd <= 1'b0;
        mem_wr <= 1'b0;
        reg_rd <= 1'b0;
        reg_wr <= 1'b0;
      end
    end
  end

  // no strobes while idle (R3)
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd | mem_wr | reg_rd | reg_wr));

  // exactly one read and one write per active byte (R3)
  assert_strobe_pair_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones({mem_rd, reg_rd}) == 1) && ($countones({mem_wr, reg_wr}) == 1)
             && (mem_rd == reg_wr));

  // done is a single pulse following the last byte (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // a start during a transfer leaves the direction alone (R2)
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(mem_rd) && $stable(mem_wr));
endmodule

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ctrl = '0;
  logic [23:0] src_start = '0;
  logic [15:0] byte_count = '0;
  logic [7:0]  reg_base = '0;
  logic        busy, done, mem_rd, mem_wr, reg_rd, reg_wr;
  logic [23:0] src_addr;
  logic [7:0]  reg_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_seq_top uut (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .src_start(src_start),
    .byte_count(byte_count), .reg_base(reg_base), .busy(busy), .done(done),
    .src_addr(src_addr), .reg_addr(reg_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .reg_rd(reg_rd), .reg_wr(reg_wr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offset for byte k under mode m, from the requirement's pattern table
  function automatic logic [7:0] want_off(input logic [2:0] m, input int k);
    int p;
    case (m)
      3'b000: return 8'd0;
      3'b001: begin p = k % 2; return (p == 0) ? 8'd0 : 8'd1; end
      3'b010, 3'b110: return 8'd0;
      3'b011, 3'b111: begin p = k % 4; return (p < 2) ? 8'd0 : 8'd1; end
      3'b100: return 8'(k % 4);
      default: begin p = k % 4; return (p == 1 || p == 3) ? 8'd1 : 8'd0; end
    endcase
  endfunction

  function automatic logic [23:0] want_src(input logic [7:0] c, input logic [23:0] s, input int k);
    logic [15:0] lo;
    if (c[3])      lo = s[15:0];
    else if (c[4]) lo = s[15:0] - 16'(k);
    else           lo = s[15:0] + 16'(k);
    return {s[23:16], lo};
  endfunction

  // full per-byte checks; poke = raise a stray start during the transfer
  task automatic run_xfer(input logic [7:0] c, input logic [23:0] s, input logic [15:0] n,
                          input logic [7:0] b, input bit poke, input bit light);
    int total;
    int busy_cycles;
    total = (n == 0) ? 65536 : int'(n);
    busy_cycles = 0;
    @(negedge clk);
    ctrl = c; src_start = s; byte_count = n; reg_base = b; start = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == 0) begin
        start = 1'b0;
        ctrl = $urandom; src_start = $urandom; byte_count = $urandom; reg_base = $urandom;
      end
      if (poke) start = (i == 1);
      if (busy) busy_cycles++;
      if (!light) begin
        chk(busy == 1'b1, "R8 busy during byte", 32'(busy), 1);
        chk(src_addr == want_src(c, s, i), c[3] ? "R7 fixed src" : "R6 src step",
            32'(src_addr), 32'(want_src(c, s, i)));
        chk(reg_addr == 8'(b + want_off(c[2:0], i)), "R4 R5 reg_addr pattern",
            32'(reg_addr), 32'(8'(b + want_off(c[2:0], i))));
        chk({mem_rd, reg_wr, reg_rd, mem_wr} == (c[7] ? 4'b0011 : 4'b1100), "R3 strobes",
            32'({mem_rd, reg_wr, reg_rd, mem_wr}), c[7] ? 32'h3 : 32'hC);
      end
    end
    start = 1'b0;
    chk(busy_cycles == total, "R8 byte count", 32'(busy_cycles), 32'(total));
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R9 done after last byte", {30'd0, done, busy}, 32'h2);
    @(negedge clk);
    chk(done == 1'b0, "R9 done is one cycle", 32'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk({busy, done, mem_rd, mem_wr, reg_rd, reg_wr} == 6'b0, "R1 reset state",
        32'({busy, done, mem_rd, mem_wr, reg_rd, reg_wr}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done} == 2'b0, "R1 idle after reset", 32'({busy, done}), 0);

    // directed: each mode, count ending mid-pattern
    for (int m = 0; m < 8; m++) run_xfer({5'b00000, 3'(m)}, 24'h7E_1000, 16'd7, 8'h18, 0, 0);
    // R2 stray start while busy, register-to-memory direction
    run_xfer(8'h84, 24'h12_3456, 16'd9, 8'h40, 1, 0);
    // R6 decrement across the 16-bit wrap, bank kept
    run_xfer(8'h13, 24'h05_0002, 16'd6, 8'h22, 0, 0);
    // R6 increment across the wrap
    run_xfer(8'h05, 24'hC0_FFFE, 16'd5, 8'hFE, 0, 0);
    // R7 fixed with decrement bit also set
    run_xfer(8'h19, 24'h33_ABCD, 16'd5, 8'h10, 0, 0);
    // R10 unused bits 6 and 5 set
    run_xfer(8'h64, 24'h01_0203, 16'd6, 8'h80, 0, 0);
    // R8 single byte
    run_xfer(8'h01, 24'h00_0000, 16'd1, 8'h00, 0, 0);
    // random mix
    for (int t = 0; t < 40; t++)
      run_xfer(8'($urandom), 24'($urandom), 16'($urandom_range(1, 20)), 8'($urandom), 0, 0);
    // R8 count 0 means 65536
    run_xfer(8'h01, 24'h7F_0000, 16'd0, 8'h00, 0, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule